// File: doc/BRIEF.md
# DMA Channel Enable and Interrupt Control

This block holds the control bits of a single DMA channel and makes the per-request decision for that channel. Four bits are kept:

- a transfer enable;
- a master enable;
- an interrupt enable for the end of a transfer;
- an interrupt enable for a break in a transfer.

Software reaches these bits through a small register port. The transfer enable is guarded against accidental setting. A write of 1 takes effect only when the last access was a read that showed the bit at 0.

Each incoming activation request meets one of three fates. It may start a transfer, when both enables are on. It may be handed to the CPU as an ordinary interrupt, when the channel is disabled and the source is an internal interrupt. Otherwise it is dropped.

The block also raises two level interrupt requests:

- A transfer-end request fires when the transfer enable drops, whether because the programmed count finished or because software forced a suspend.
- A transfer-break request fires when the master enable drops. Software can withdraw it by clearing its enable or by turning the master enable back on.

Top module: `dmac_chan_ctl`

## Requirements
- R1: After a synchronous active-low reset, every control bit, the read value and all outputs are 0.
- R2: The transfer enable (bit 0 of the control word) becomes 1 only through a write with bit 0 = 1 that follows a read which returned bit 0 = 0, with no write in between. Any other write of 1 to bit 0 leaves a 0 unchanged.
- R3: The transfer enable clears on a write with bit 0 = 0, and on `cnt_done` (which takes priority over a same-cycle write).
- R4: Bits 1 (master enable), 2 (end interrupt enable) and 3 (break interrupt enable) take the written value directly. `rd_data` always shows the four bits combinationally.
- R5: An activation request in a cycle where transfer enable and master enable are both 1 gives a one-cycle `xfer_go` pulse in the next cycle.
- R6: An activation request flagged as an internal interrupt, while the transfer enable is 0, gives a one-cycle `cpu_irq` pulse in the next cycle and no `xfer_go`.
- R7: When the transfer enable falls while the end interrupt enable is 1, `end_irq` rises in the next cycle. It stays high until the end interrupt enable becomes 0.
- R8: When the master enable falls while the break interrupt enable is 1, `brk_irq` rises in the next cycle and stays high.
- R9: A high `brk_irq` drops on the cycle after the break interrupt enable is cleared or the master enable is written back to 1.
- R10: While the transfer enable is 1 and the master enable is 0, an activation request produces neither `xfer_go` nor `cpu_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| rd_en | input | 1 | Control word read strobe |
| wr_data | input | 4 | Write value: bit0 transfer enable, bit1 master enable, bit2 end IE, bit3 break IE |
| rd_data | output | 4 | Current control word, same layout |
| act_req | input | 1 | Activation request from the selected source |
| act_is_irq | input | 1 | The activation source is an internal interrupt |
| cnt_done | input | 1 | Programmed transfer count reached |
| xfer_go | output | 1 | One-cycle transfer start pulse |
| cpu_irq | output | 1 | One-cycle forwarded interrupt pulse |
| end_irq | output | 1 | Transfer-end interrupt request (level) |
| brk_irq | output | 1 | Transfer-break interrupt request (level) |

## Verification
The assertions check several properties on every cycle:

- a rise of the transfer enable always traces back to an armed write;
- a count completion always leaves the channel disabled;
- start and forward pulses never coincide, and each matches the request and enable state of the prior cycle;
- an interrupt request never stands without its enable, and a break request never stands while the master enable is on.

Other behaviour can only be shown by the bench's scenarios. That covers the read-then-write handshake being disarmed by an intervening write, the same-cycle priority of count completion over a write, and the exact cycle in which each interrupt rises and is withdrawn. The bench also runs a reference model against random traffic for comparison.

// File: rtl/dmac_ctl_pkg.sv
// Package: shared control-word layout for the DMA channel control block.
// Assumes a four-bit control word; positions are fixed because software
// decodes them.
package dmac_ctl_pkg;
    localparam int CTL_W   = 4;
    localparam int XEN_POS = 0;
    localparam int MEN_POS = 1;
    localparam int EIE_POS = 2;
    localparam int BIE_POS = 3;

    typedef struct packed {
        logic bie;   // break interrupt enable
        logic eie;   // end interrupt enable
        logic men;   // master enable
        logic xen;   // transfer enable
    } ctl_bits_t;
endpackage

// File: rtl/dmac_ctl_regs.sv
// Module: control bit storage with a guarded transfer-enable set.
// What it does: holds the four control bits, arms a set permission on a read
// that shows transfer enable at 0, and disarms it on any write. It exposes the
// next-state bits and fall events so that the interrupt logic can react in the
// same cycle.
// Assumes: write has priority over a same-cycle read; cnt_done overrides writes.
module dmac_ctl_regs
    import dmac_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             cnt_done,
    output ctl_bits_t        ctl_q,
    output ctl_bits_t        ctl_d,
    output logic             xen_fall,
    output logic             men_fall
);
    logic armed_q;
    logic armed_d;

    // Purpose: compute the next control bits and the arm flag.
    always_comb begin
        ctl_d   = ctl_q;
        armed_d = armed_q;
        if (wr_en) begin
            armed_d = 1'b0;
            ctl_d.men = wr_data[MEN_POS];
            ctl_d.eie = wr_data[EIE_POS];
            ctl_d.bie = wr_data[BIE_POS];
            if (!wr_data[XEN_POS]) begin
                ctl_d.xen = 1'b0;
            end else if (armed_q) begin
                ctl_d.xen = 1'b1;
            end
        end else if (rd_en && !ctl_q.xen) begin
            armed_d = 1'b1;
        end
        if (cnt_done) begin
            ctl_d.xen = 1'b0;
        end
    end

    // Purpose: detect falling edges of the two enables in the current cycle.
    always_comb begin
        xen_fall = ctl_q.xen & ~ctl_d.xen;
        men_fall = ctl_q.men & ~ctl_d.men;
    end

    // Purpose: register the control bits and the arm flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            ctl_q   <= ctl_d;
            armed_q <= armed_d;
        end
    end

    AST_XEN_SET_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.xen && !(wr_en && armed_q && wr_data[XEN_POS])) |=> !ctl_q.xen); // R2
    AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !armed_q); // R2
    AST_COUNT_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_done |=> !ctl_q.xen); // R3
    AST_ZERO_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[XEN_POS]) |=> !ctl_q.xen); // R3
endmodule

// File: rtl/dmac_req_route.sv
// Module: activation request routing.
// What it does: decides per request whether to start a transfer, forward the
// request to the CPU as an interrupt, or drop it. Both outputs are registered
// one-cycle pulses.
// Assumes: act_req is valid for one cycle per request.
module dmac_req_route
    import dmac_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ctl_bits_t ctl_q,
    input  logic      act_req,
    input  logic      act_is_irq,
    output logic      xfer_go,
    output logic      cpu_irq
);
    logic go_d;
    logic fwd_d;

    // Purpose: classify the current request against the enable state.
    always_comb begin
        go_d  = act_req & ctl_q.xen & ctl_q.men;
        fwd_d = act_req & act_is_irq & ~ctl_q.xen;
    end

    // Purpose: register the start and forward pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_go <= 1'b0;
            cpu_irq <= 1'b0;
        end else begin
            xfer_go <= go_d;
            cpu_irq <= fwd_d;
        end
    end

    AST_START_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (act_req && ctl_q.xen && ctl_q.men) |=> xfer_go); // R5
    AST_FWD_ONLY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (act_req && act_is_irq && !ctl_q.xen) |=> (cpu_irq && !xfer_go)); // R6
    AST_HALF_ENABLED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.xen && !ctl_q.men) |=> (!xfer_go && !cpu_irq)); // R10
endmodule

// File: rtl/dmac_irq_gen.sv
// Module: transfer-end and transfer-break interrupt requests.
// What it does: sets a level request on each enable fall while the matching
// interrupt enable is on. The end request holds until its enable is cleared.
// The break request also drops when the master enable returns.
// Assumes: fall events and next-state bits come from the same cycle.
module dmac_irq_gen
    import dmac_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ctl_bits_t ctl_q,
    input  ctl_bits_t ctl_d,
    input  logic      xen_fall,
    input  logic      men_fall,
    output logic      end_irq,
    output logic      brk_irq
);
    logic end_d;
    logic brk_d;

    // Purpose: next request levels from set events and cancel conditions.
    always_comb begin
        end_d = (xen_fall | end_irq) & ctl_d.eie;
        brk_d = (men_fall | brk_irq) & ctl_d.bie & ~ctl_d.men;
    end

    // Purpose: hold the request levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_irq <= 1'b0;
            brk_irq <= 1'b0;
        end else begin
            end_irq <= end_d;
            brk_irq <= brk_d;
        end
    end

    AST_END_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |-> ctl_q.eie); // R7
    AST_BRK_IRQ_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq |-> (ctl_q.bie && !ctl_q.men)); // R9
    AST_BRK_ON_MEN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.men && ctl_q.bie && !ctl_d.men && ctl_d.bie) |=> brk_irq); // R8
endmodule

// File: rtl/dmac_chan_ctl.sv
// Module: top of the DMA channel enable and interrupt control block.
// What it does: connects the control registers, the request router and the
// interrupt generator, and presents the control word for reading.
// Assumes: one channel per instance; the caller decodes register selection.
module dmac_chan_ctl
    import dmac_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    input  logic             act_req,
    input  logic             act_is_irq,
    input  logic             cnt_done,
    output logic             xfer_go,
    output logic             cpu_irq,
    output logic             end_irq,
    output logic             brk_irq
);
    ctl_bits_t ctl_q;
    ctl_bits_t ctl_d;
    logic      xen_fall;
    logic      men_fall;

    dmac_ctl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_data  (wr_data),
        .cnt_done (cnt_done),
        .ctl_q    (ctl_q),
        .ctl_d    (ctl_d),
        .xen_fall (xen_fall),
        .men_fall (men_fall)
    );

    dmac_req_route u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_q      (ctl_q),
        .act_req    (act_req),
        .act_is_irq (act_is_irq),
        .xfer_go    (xfer_go),
        .cpu_irq    (cpu_irq)
    );

    dmac_irq_gen u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_q    (ctl_q),
        .ctl_d    (ctl_d),
        .xen_fall (xen_fall),
        .men_fall (men_fall),
        .end_irq  (end_irq),
        .brk_irq  (brk_irq)
    );

    // Purpose: present the control word on the read port.
    always_comb begin
        rd_data = ctl_q;
    end

    AST_NEVER_GO_AND_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_go && cpu_irq)); // R10
endmodule

// File: tb/dmac_chan_ctl_test.sv
// Bench: directed scenarios plus random traffic against a behavioural model
// that is compared on every negative clock edge.
module dmac_chan_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic [3:0] rd_data;
    logic       act_req = 1'b0;
    logic       act_is_irq = 1'b0;
    logic       cnt_done = 1'b0;
    logic       xfer_go, cpu_irq, end_irq, brk_irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    dmac_chan_ctl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .act_req(act_req),
        .act_is_irq(act_is_irq), .cnt_done(cnt_done), .xfer_go(xfer_go),
        .cpu_irq(cpu_irq), .end_irq(end_irq), .brk_irq(brk_irq)
    );

    // Reference model state.
    bit m_en, m_mst, m_eie, m_bie, m_arm, m_go, m_fwd, m_end, m_brk;

    always @(posedge clk) begin
        bit was_en, was_mst;
        if (!rst_n) begin
            {m_en, m_mst, m_eie, m_bie, m_arm, m_go, m_fwd, m_end, m_brk} = '0;
        end else begin
            was_en  = m_en;
            was_mst = m_mst;
            m_go  = act_req && m_en && m_mst;
            m_fwd = act_req && act_is_irq && !m_en;
            if (wr_en) begin
                m_mst = wr_data[1];
                m_eie = wr_data[2];
                m_bie = wr_data[3];
                if (wr_data[0] == 1'b0) m_en = 0;
                else if (m_arm) m_en = 1;
                m_arm = 0;
            end else if (rd_en && !m_en) begin
                m_arm = 1;
            end
            if (cnt_done) m_en = 0;
            if (was_en && !m_en && m_eie) m_end = 1;
            if (!m_eie) m_end = 0;
            if (was_mst && !m_mst && m_bie) m_brk = 1;
            if (!m_bie || m_mst) m_brk = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        cycles++;
        chk("R4 rd_data", rd_data, {m_bie, m_eie, m_mst, m_en});
        chk("R5 xfer_go", xfer_go, m_go);
        chk("R6 cpu_irq", cpu_irq, m_fwd);
        chk("R7 end_irq", end_irq, m_end);
        chk("R8 brk_irq", brk_irq, m_brk);
    end

    task automatic drive(input bit w, input bit r, input logic [3:0] d,
                         input bit a, input bit ii, input bit c);
        @(posedge clk);
        #1;
        wr_en = w; rd_en = r; wr_data = d;
        act_req = a; act_is_irq = ii; cnt_done = c;
    endtask

    task automatic idle();
        drive(0, 0, 4'h0, 0, 0, 0);
    endtask

    task automatic wr(input logic [3:0] d);
        drive(1, 0, d, 0, 0, 0);
    endtask

    task automatic rd();
        drive(0, 1, 4'h0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        wait (cycles > 100000);
        chk("watchdog", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle();
        // R1 reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 outputs", {xfer_go, cpu_irq, end_irq, brk_irq}, 0);

        // R2 write of 1 without prior read is ignored
        wr(4'b0001); idle();
        chk("R2 unarmed set", rd_data[0], 0);
        // R2 read then write sets; R4 master enable written directly
        rd(); wr(4'b0011); idle();
        chk("R2 armed set", rd_data, 4'b0011);
        // R5 start pulse
        drive(0, 0, 0, 1, 1, 0); idle();
        chk("R5 go", xfer_go, 1);
        chk("R5 no fwd", cpu_irq, 0);
        idle();
        chk("R5 single pulse", xfer_go, 0);
        // R4 write end IE while enable stays
        wr(4'b0111); idle();
        chk("R4 word", rd_data, 4'b0111);
        // R3 count done clears; R7 end interrupt
        drive(0, 0, 0, 0, 0, 1); idle();
        chk("R3 done clears", rd_data[0], 0);
        chk("R7 end rise", end_irq, 1);
        idle();
        chk("R7 end held", end_irq, 1);
        // R6 forward while disabled
        drive(0, 0, 0, 1, 1, 0); idle();
        chk("R6 fwd", cpu_irq, 1);
        chk("R6 no go", xfer_go, 0);
        // R7 cleared by writing end IE 0
        wr(4'b0010); idle();
        chk("R7 end cleared", end_irq, 0);
        // R8 break on master fall; R9 cancel by re-enable
        wr(4'b1010); wr(4'b1000); idle();
        chk("R8 brk rise", brk_irq, 1);
        wr(4'b1010); idle();
        chk("R9 cancel by master", brk_irq, 0);
        wr(4'b1000); idle();
        chk("R8 brk again", brk_irq, 1);
        wr(4'b0000); idle();
        chk("R9 cancel by ie", brk_irq, 0);
        // R10 half enabled drops request
        rd(); wr(4'b0001); drive(0, 0, 0, 1, 1, 0); idle();
        chk("R10 no go", xfer_go, 0);
        chk("R10 no fwd", cpu_irq, 0);
        // R3 software write 0 clears; R7 end raised
        wr(4'b0101); wr(4'b0100); idle();
        chk("R3 sw clear", rd_data[0], 0);
        chk("R7 end on sw clear", end_irq, 1);
        // R2 intervening write disarms
        rd(); wr(4'b0000); wr(4'b0001); idle();
        chk("R2 disarmed", rd_data[0], 0);
        // R3 count done beats a same-cycle armed set
        rd(); drive(1, 0, 4'b0001, 0, 0, 1); idle();
        chk("R3 done priority", rd_data[0], 0);

        // random traffic, compared against the model each cycle
        for (int i = 0; i < 2000; i++) begin
            drive($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
                  4'($urandom), $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0);
        end
        idle(); idle();
        finish_run();
    end
endmodule